// File: doc/BRIEF.md
# Packet-Complete Auto-Exit Mode Sequencer

This block holds the operating mode of a packet radio. Software writes a 4-bit mode control word. Two of its bits request transmit or receive. The other two bits choose the state the radio rests in when it is not active. The block turns that word into a current operating state.

When the data path runs from the packet buffer (buffered mode), the block watches two event pulses. A packet-sent pulse ends transmit and a valid-packet pulse ends receive. On either event the block clears the active request bit in its own copy of the control word and falls back to the resting state that the remaining bits select. It also raises an interrupt pulse and a sticky completion flag. When the data path is driven straight from a pin (direct mode), no event ends the active state. Software must then clear the request bit itself.

Top module: `mode_seq`

## Requirements
- R1: After reset, state_o is 0 (STANDBY), ctrl_o is 0, irq_o is 0 and stat_o is 0.
- R2: The control word has these bits: bit 0 crystal-on, bit 1 synthesizer-on, bit 2 receive-on, bit 3 transmit-on. A write is visible on ctrl_o and state_o one clock after the write cycle. The state codes are 0 STANDBY, 1 READY, 2 TUNE, 3 TX and 4 RX. With transmit-on set the state is TX; with only receive-on set it is RX.
- R3: In buffered mode (fifo_mode_i=1), a pkt_sent_i pulse while in TX clears ctrl bit 3 and leaves TX on the next clock.
- R4: In buffered mode, a pkt_valid_i pulse while in RX clears ctrl bit 2 and leaves RX on the next clock.
- R5: When no on-bit is set, the state is chosen as follows: TUNE if bit 1 is set; otherwise READY if bit 0 is set; otherwise STANDBY. This also applies after an auto-exit.
- R6: In direct mode (fifo_mode_i=0), packet events have no effect: the state, the control word, the interrupt and the flags are all unchanged.
- R7: Each auto-exit drives irq_o high for exactly one cycle, on the same cycle as the state change. It also sets stat_o bit 0 (transmit done) or bit 1 (receive done). A stat_rd_i cycle clears the flags on the next clock.
- R8: A packet event that does not match the current state has no effect. This covers pkt_sent_i outside TX and pkt_valid_i outside RX.
- R9: Writing transmit-on while already in TX keeps the state in TX and raises no interrupt.
- R10: If a write sets both transmit-on and receive-on, the state becomes TX and ctrl bit 2 is stored as 0.
- R11: A control write in the same cycle as a packet event takes precedence. The written word is stored and the event is dropped, with no interrupt.
- R12: A flag set by an auto-exit in the same cycle as stat_rd_i stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 4 | Control word write data |
| fifo_mode_i | input | 1 | 1 = buffered data path, 0 = direct pin data path |
| pkt_sent_i | input | 1 | Packet-sent event pulse |
| pkt_valid_i | input | 1 | Valid-packet event pulse |
| stat_rd_i | input | 1 | Status read strobe; clears the completion flags |
| state_o | output | 3 | Current operating state |
| ctrl_o | output | 4 | Current control word |
| irq_o | output | 1 | One-cycle auto-exit interrupt |
| stat_o | output | 2 | Sticky completion flags: bit 0 transmit, bit 1 receive |

## Verification
Every result of this block is registered once. A write, an event or a status read that is sampled on one rising edge shows up on state_o, ctrl_o, irq_o and stat_o just after that edge, and not before. The driver applies each stimulus on the falling edge and queues the expected port values for that single cycle. The monitor compares them 1 ns after the following rising edge. Each cycle therefore has exactly one expectation, which catches a result that is late, early, missing or stretched over two cycles.

// File: rtl/mode_seq_pkg.sv
package mode_seq_pkg;
  parameter int unsigned CTRL_W = 4;
  parameter int unsigned STAT_W = 2;
  parameter int unsigned STATE_W = 3;

  localparam int unsigned XTAL_B = 0;
  localparam int unsigned PLL_B  = 1;
  localparam int unsigned RX_B   = 2;
  localparam int unsigned TX_B   = 3;

  localparam int unsigned DONE_TX = 0;
  localparam int unsigned DONE_RX = 1;

  typedef enum logic [STATE_W-1:0] {
    MS_STANDBY = 3'd0,
    MS_READY   = 3'd1,
    MS_TUNE    = 3'd2,
    MS_TX      = 3'd3,
    MS_RX      = 3'd4
  } mode_e;

  function automatic mode_e decode_mode(input logic [CTRL_W-1:0] c);
    if (c[TX_B])        return MS_TX;
    else if (c[RX_B])   return MS_RX;
    else if (c[PLL_B])  return MS_TUNE;
    else if (c[XTAL_B]) return MS_READY;
    else                return MS_STANDBY;
  endfunction
endpackage

// File: rtl/mode_ctrl_reg.sv
module mode_ctrl_reg
  import mode_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] exit_i,
  output logic [CTRL_W-1:0] ctrl_d_o,
  output logic [CTRL_W-1:0] ctrl_q_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) begin
      ctrl_d = wdata_i;
      if (wdata_i[TX_B]) ctrl_d[RX_B] = 1'b0; // transmit wins
    end else begin
      if (exit_i[DONE_TX]) ctrl_d[TX_B] = 1'b0;
      if (exit_i[DONE_RX]) ctrl_d[RX_B] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_d_o = ctrl_d;
  assign ctrl_q_o = ctrl_q;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import mode_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              fifo_mode_i,
  input  logic              sent_i,
  input  logic              valid_i,
  input  logic [CTRL_W-1:0] ctrl_d_i,
  output logic [STAT_W-1:0] exit_o,
  output mode_e             state_o
);
  mode_e state_q;
  logic  armed;

  // events count only in buffered mode and without a competing write
  assign armed            = fifo_mode_i && !we_i;
  assign exit_o[DONE_TX]  = armed && sent_i  && (state_q == MS_TX);
  assign exit_o[DONE_RX]  = armed && valid_i && (state_q == MS_RX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MS_STANDBY;
    else         state_q <= decode_mode(ctrl_d_i);
  end

  assign state_o = state_q;
endmodule

// File: rtl/done_flags.sv
module done_flags
  import mode_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] flag_o,
  output logic              irq_o
);
  logic irq_q;

  for (genvar g = 0; g < STAT_W; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_i[g]) f_q <= 1'b1; // set beats read-clear
      else if (rd_i)     f_q <= 1'b0;
    end
    assign flag_o[g] = f_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |set_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mode_seq.sv
module mode_seq
  import mode_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              fifo_mode_i,
  input  logic              pkt_sent_i,
  input  logic              pkt_valid_i,
  input  logic              stat_rd_i,
  output logic [STATE_W-1:0] state_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o,
  output logic [STAT_W-1:0] stat_o
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [STAT_W-1:0] exit_v;
  mode_e             state;

  mode_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .exit_i   (exit_v),
    .ctrl_d_o (ctrl_d),
    .ctrl_q_o (ctrl_o)
  );

  mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we_i),
    .fifo_mode_i (fifo_mode_i),
    .sent_i      (pkt_sent_i),
    .valid_i     (pkt_valid_i),
    .ctrl_d_i    (ctrl_d),
    .exit_o      (exit_v),
    .state_o     (state)
  );

  done_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (exit_v),
    .rd_i   (stat_rd_i),
    .flag_o (stat_o),
    .irq_o  (irq_o)
  );

  assign state_o = state;
endmodule

// File: rtl/mode_seq_chk.sv
module mode_seq_chk
  import mode_seq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ctrl_we_i,
  input logic               fifo_mode_i,
  input logic               pkt_sent_i,
  input logic               pkt_valid_i,
  input logic [STATE_W-1:0] state_o,
  input logic [CTRL_W-1:0]  ctrl_o,
  input logic               irq_o,
  input logic [STAT_W-1:0]  stat_o
);
  assert_tx_state_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) == ctrl_o[TX_B]);

  assert_tx_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && fifo_mode_i && pkt_sent_i && !ctrl_we_i)
      |=> (state_o != 3'd3 && !ctrl_o[TX_B] && irq_o && stat_o[DONE_TX]));

  assert_rx_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && fifo_mode_i && pkt_valid_i && !ctrl_we_i)
      |=> (state_o != 3'd4 && !ctrl_o[RX_B] && irq_o && stat_o[DONE_RX]));

  assert_direct_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode_i |=> !irq_o);

  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_idle_no_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd3 && state_o != 3'd4) |=> !irq_o);

  assert_tx_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[TX_B] |-> !ctrl_o[RX_B]);

  assert_write_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !irq_o);
endmodule

bind mode_seq mode_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .fifo_mode_i (fifo_mode_i),
  .pkt_sent_i  (pkt_sent_i),
  .pkt_valid_i (pkt_valid_i),
  .state_o     (state_o),
  .ctrl_o      (ctrl_o),
  .irq_o       (irq_o),
  .stat_o      (stat_o)
);

// File: tb/sim_mode_seq.sv
`timescale 1ns/1ps
module sim_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] wdata = '0;
  logic       fifo = 1'b1;
  logic       sent = 1'b0;
  logic       valid = 1'b0;
  logic       rd = 1'b0;
  logic [2:0] state;
  logic [3:0] ctrl;
  logic       irq;
  logic [1:0] stat;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [2:0] st;
    logic [3:0] ct;
    logic       iq;
    logic [1:0] sf;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  mode_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .fifo_mode_i(fifo), .pkt_sent_i(sent), .pkt_valid_i(valid), .stat_rd_i(rd),
    .state_o(state), .ctrl_o(ctrl), .irq_o(irq), .stat_o(stat)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (state !== e.st || ctrl !== e.ct || irq !== e.iq || stat !== e.sf) begin
      fails++;
      $display("FAIL %s: got st=%0d ctrl=%b irq=%b stat=%b exp st=%0d ctrl=%b irq=%b stat=%b",
               e.req, state, ctrl, irq, stat, e.st, e.ct, e.iq, e.sf);
    end
  endtask

  // one cycle of stimulus plus the port values due right after the next edge
  task automatic step(input logic w, input logic [3:0] d, input logic fm,
                      input logic s, input logic v, input logic r,
                      input logic [2:0] est, input logic [3:0] ect,
                      input logic eiq, input logic [1:0] esf, input string req);
    exp_t e;
    @(negedge clk);
    we = w; wdata = d; fifo = fm; sent = s; valid = v; rd = r;
    e.st = est; e.ct = ect; e.iq = eiq; e.sf = esf; e.req = req;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung run, exp completion");
    report();
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.st = 3'd0; r.ct = 4'b0000; r.iq = 1'b0; r.sf = 2'b00; r.req = "R1 reset";
    compare(r);
    rst_n = 1'b1;
    //   we d       fm s v r   st  ctrl     irq stat
    step(1, 4'b1010, 1, 0, 0, 0, 3, 4'b1010, 0, 2'b00, "R2 enter TX");
    step(0, 4'b0000, 1, 0, 0, 0, 3, 4'b1010, 0, 2'b00, "R2 hold TX");
    step(1, 4'b1010, 1, 0, 0, 0, 3, 4'b1010, 0, 2'b00, "R9 rewrite TX");
    step(0, 4'b0000, 1, 1, 0, 0, 2, 4'b0010, 1, 2'b01, "R3 R5 tx exit to TUNE");
    step(0, 4'b0000, 1, 0, 0, 0, 2, 4'b0010, 0, 2'b01, "R7 irq one cycle");
    step(0, 4'b0000, 1, 0, 0, 1, 2, 4'b0010, 0, 2'b00, "R7 read clears");
    step(0, 4'b0000, 1, 1, 0, 0, 2, 4'b0010, 0, 2'b00, "R8 sent in TUNE");
    step(1, 4'b0100, 1, 0, 0, 0, 4, 4'b0100, 0, 2'b00, "R2 enter RX");
    step(0, 4'b0000, 1, 1, 0, 0, 4, 4'b0100, 0, 2'b00, "R8 sent in RX");
    step(0, 4'b0000, 1, 0, 1, 0, 0, 4'b0000, 1, 2'b10, "R4 R5 rx exit to STANDBY");
    step(0, 4'b0000, 1, 0, 0, 0, 0, 4'b0000, 0, 2'b10, "R7 rx flag sticky");
    step(1, 4'b1100, 1, 0, 0, 0, 3, 4'b1000, 0, 2'b10, "R10 tx priority");
    step(1, 4'b1001, 1, 0, 0, 0, 3, 4'b1001, 0, 2'b10, "R9 rewrite keeps TX");
    step(0, 4'b0000, 1, 1, 0, 0, 1, 4'b0001, 1, 2'b11, "R3 R5 tx exit to READY");
    step(0, 4'b0000, 1, 0, 0, 1, 1, 4'b0001, 0, 2'b00, "R7 read clears both");
    step(1, 4'b0100, 0, 0, 0, 0, 4, 4'b0100, 0, 2'b00, "R2 direct RX");
    step(0, 4'b0000, 0, 0, 1, 0, 4, 4'b0100, 0, 2'b00, "R6 direct ignores valid");
    step(0, 4'b0000, 0, 1, 1, 0, 4, 4'b0100, 0, 2'b00, "R6 direct ignores both");
    step(1, 4'b0000, 0, 0, 0, 0, 0, 4'b0000, 0, 2'b00, "R6 software clears RX");
    step(1, 4'b1000, 1, 0, 0, 0, 3, 4'b1000, 0, 2'b00, "R2 enter TX again");
    step(1, 4'b1000, 1, 1, 0, 0, 3, 4'b1000, 0, 2'b00, "R11 write beats event");
    step(0, 4'b0000, 1, 0, 1, 0, 3, 4'b1000, 0, 2'b00, "R8 valid in TX");
    step(0, 4'b0000, 1, 1, 0, 1, 0, 4'b0000, 1, 2'b01, "R12 set beats read");
    step(0, 4'b0000, 1, 0, 0, 0, 0, 4'b0000, 0, 2'b01, "R12 flag kept");
    step(0, 4'b0000, 1, 0, 0, 0, 0, 4'b0000, 0, 2'b01, "R1 quiet");
    @(negedge clk);
    we = 0; sent = 0; valid = 0; rd = 0;
    repeat (3) @(posedge clk);
    #2;
    report();
    $finish;
  end
endmodule